// File: doc/BRIEF.md
# Packet Sync Finder and Twelve-Branch Convolutional Deinterleaver

This block sits between a cable demodulator's symbol-to-byte stage and the Reed-Solomon decoder. It watches the incoming byte stream for the transport packet sync marker, which opens every 204-byte packet. The marker value is 0x47, and its bitwise complement 0xB8 is also accepted. A candidate marker must recur exactly 204 accepted bytes later. After a configurable number of consecutive well-spaced markers, the block declares lock.

Once locked, every accepted byte enters a twelve-branch convolutional deinterleaver of the Forney type. Its commutator is pinned to the packet grid, so the marker byte always enters branch 0. Branch j holds (11 - j) * 17 of its own visits, so byte bursts that the interleaver spread out are gathered back into order. All branch FIFOs are circular regions of one shared byte RAM. Output starts once every branch has been filled. A packet-start flag marks each output byte that carries a marker. Lock is dropped after four expected marker slots in a row hold no marker, and the search then starts over.

Top module: `dlv_top`

## Requirements
- R1: After synchronous reset, `locked`, `out_valid` and `out_start` are 0.
- R2: Only 0x47 and 0xB8 count as markers. A stream that never contains either value never produces lock.
- R3: The first marker seen while searching becomes packet position 0. Lock is declared on the clock edge of the marker that makes `lock_count` consecutive markers, each 204 accepted bytes after the previous one. A `lock_count` of 0 acts as 1, so lock comes on the first marker.
- R4: While lock is being confirmed, a non-marker byte at an expected slot sends the block back to searching. No lock is declared from that run.
- R5: While locked, up to three consecutive expected slots without a marker keep lock. A marker resets the miss run. The fourth consecutive miss clears `locked` on that byte's edge.
- R6: Number the accepted bytes from 0, starting with the byte that completes lock; byte k goes to branch k mod 12. The output for byte k appears one cycle after it is accepted and equals accepted byte k - 204 * (11 - (k mod 12)).
- R7: `out_valid` is high only for one cycle after an accepted byte with k >= 2244. Cycles with `in_valid` low produce no output and do not move the packet position, whatever `in_byte` holds.
- R8: `out_start` is high exactly on valid outputs for which k mod 204 == 0, that is, the byte that carries the marker after deinterleaving.
- R9: While not locked, no byte enters the deinterleaver and `out_valid` stays 0. After a relock, output resumes only after another 2244 accepted bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Byte from the demodulator |
| in_valid | input | 1 | `in_byte` is accepted this cycle |
| lock_count | input | 4 | Consecutive markers needed for lock (0 treated as 1) |
| out_byte | output | 8 | Deinterleaved byte |
| out_valid | output | 1 | `out_byte` holds a valid byte |
| out_start | output | 1 | Valid output byte carries the packet marker |
| locked | output | 1 | Packet grid is locked |

## Verification
The bench compares every cycle against a byte-level reference model. It feeds both marker polarities, idle cycles carrying 0x47 (which would shift the grid if the block accepted them), and random payload that never forms a false marker.

Three corner cases get directed runs:
- Exactly three missed markers, followed by a recovery and then four misses. A miss counter that is off by one either drops lock too early or never drops it.
- A broken marker run during confirmation with `lock_count` of 4. A design that tolerated the gap would lock at the wrong time.
- A `lock_count` of 0, which must lock on the first marker.

Output checks start at exactly the 2244th byte after lock. A wrong branch delay or base address shows up as a byte mismatch, and a wrong fill threshold as a `out_valid` mismatch.

// File: rtl/dlv_pkg.sv
package dlv_pkg;
    localparam int PKT_LEN    = 204;
    localparam int BRANCHES   = 12;
    localparam int UNIT       = PKT_LEN / BRANCHES;
    localparam int MISS_LIMIT = 4;
    localparam logic [7:0] SYNC_A = 8'h47;
    localparam logic [7:0] SYNC_B = 8'hB8;

    localparam int RAM_DEPTH = UNIT * BRANCHES * (BRANCHES - 1) / 2;
    localparam int FILL      = UNIT * BRANCHES * (BRANCHES - 1);
    localparam int POS_W     = $clog2(PKT_LEN);
    localparam int BR_W      = $clog2(BRANCHES);
    localparam int AW        = $clog2(RAM_DEPTH);
    localparam int FILL_W    = $clog2(FILL + 1);
    localparam int PTR_W     = $clog2(UNIT * (BRANCHES - 1) + 1);
    localparam int MISS_W    = $clog2(MISS_LIMIT + 1);

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_TRACK  = 2'd1,
        ST_LOCKED = 2'd2
    } sync_state_e;

    typedef struct packed {
        logic            feed;
        logic [BR_W-1:0] branch;
        logic            start;
    } slot_t;

    function automatic int branch_depth(input int j);
        return UNIT * (BRANCHES - 1 - j);
    endfunction

    function automatic int branch_base(input int j);
        return UNIT * (j * (BRANCHES - 1) - (j * (j - 1)) / 2);
    endfunction

    function automatic logic is_marker(input logic [7:0] b);
        return (b == SYNC_A) || (b == SYNC_B);
    endfunction
endpackage

// File: rtl/dlv_frame_sync.sv
module dlv_frame_sync
    import dlv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  in_byte,
    input  logic        in_valid,
    input  logic [3:0]  lock_count,
    output slot_t       slot,
    output logic        locked
);
    localparam logic [POS_W-1:0]  POS_LAST = POS_W'(PKT_LEN - 1);
    localparam logic [BR_W-1:0]   BR_LAST  = BR_W'(BRANCHES - 1);
    localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(MISS_LIMIT - 1);

    sync_state_e       st_q, st_d;
    logic [POS_W-1:0]  pos_q, pos_d;
    logic [BR_W-1:0]   br_q, br_d;
    logic [4:0]        hits_q, hits_d;
    logic [MISS_W-1:0] miss_q, miss_d;
    logic [4:0]        target;
    logic              mark, wrap;

    always_comb begin
        mark   = is_marker(in_byte);
        target = (lock_count == 4'd0) ? 5'd1 : {1'b0, lock_count};
        wrap   = (pos_q == POS_LAST);
        st_d   = st_q;
        pos_d  = pos_q;
        br_d   = br_q;
        hits_d = hits_q;
        miss_d = miss_q;
        if (in_valid) begin
            if (st_q == ST_SEARCH) begin
                if (mark) begin
                    pos_d  = '0;
                    br_d   = '0;
                    hits_d = 5'd1;
                    miss_d = '0;
                    st_d   = (target <= 5'd1) ? ST_LOCKED : ST_TRACK;
                end
            end else begin
                pos_d = wrap ? '0 : pos_q + 1'b1;
                br_d  = (wrap || br_q == BR_LAST) ? '0 : br_q + 1'b1;
                if (wrap) begin
                    if (st_q == ST_TRACK) begin
                        if (mark) begin
                            hits_d = hits_q + 5'd1;
                            if (hits_q + 5'd1 >= target) st_d = ST_LOCKED;
                        end else begin
                            st_d = ST_SEARCH;
                        end
                    end else if (mark) begin
                        miss_d = '0;
                    end else if (miss_q == MISS_TOP) begin
                        miss_d = '0;
                        st_d   = ST_SEARCH;
                    end else begin
                        miss_d = miss_q + 1'b1;
                    end
                end
            end
        end
        slot.feed   = in_valid && (st_d == ST_LOCKED);
        slot.branch = br_d;
        slot.start  = (pos_d == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_SEARCH;
            pos_q  <= '0;
            br_q   <= '0;
            hits_q <= '0;
            miss_q <= '0;
        end else begin
            st_q   <= st_d;
            pos_q  <= pos_d;
            br_q   <= br_d;
            hits_q <= hits_d;
            miss_q <= miss_d;
        end
    end

    assign locked = (st_q == ST_LOCKED);

    AST_LOCK_ON_MARKER: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(in_valid && is_marker(in_byte))); // R3
    AST_MISS_BOUND: assert property (@(posedge clk) disable iff (rst)
        miss_q < MISS_W'(MISS_LIMIT)); // R5
    AST_IDLE_HOLDS_GRID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(pos_q)); // R7
    AST_DROP_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(in_valid && !is_marker(in_byte))); // R5
endmodule

// File: rtl/dlv_commutator.sv
module dlv_commutator
    import dlv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            feed,
    input  logic [BR_W-1:0] branch,
    output logic [AW-1:0]   addr,
    output logic            bypass
);
    logic [PTR_W-1:0] ptr [BRANCHES];

    for (genvar j = 0; j < BRANCHES; j++) begin : g_br
        localparam int D = branch_depth(j);
        if (D > 0) begin : g_fifo
            logic [PTR_W-1:0] ptr_q;
            always_ff @(posedge clk) begin
                if (rst) ptr_q <= '0;
                else if (feed && branch == BR_W'(j))
                    ptr_q <= (ptr_q == PTR_W'(D - 1)) ? '0 : ptr_q + 1'b1;
            end
            assign ptr[j] = ptr_q;
            AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
                ptr_q < PTR_W'(D)); // R6
        end else begin : g_pass
            assign ptr[j] = '0;
        end
    end

    always_comb begin
        addr = '0;
        for (int j = 0; j < BRANCHES; j++)
            if (branch == BR_W'(j)) addr = AW'(branch_base(j)) + AW'(ptr[j]);
        bypass = (branch == BR_W'(BRANCHES - 1));
    end
endmodule

// File: rtl/dlv_delay_ram.sv
module dlv_delay_ram
    import dlv_pkg::*;
(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [RAM_DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            rdata     <= mem[addr];
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/dlv_top.sv
module dlv_top
    import dlv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_byte,
    input  logic       in_valid,
    input  logic [3:0] lock_count,
    output logic [7:0] out_byte,
    output logic       out_valid,
    output logic       out_start,
    output logic       locked
);
    slot_t             slot;
    logic [AW-1:0]     addr;
    logic              bypass;
    logic [7:0]        ram_q, byp_q;
    logic              sel_byp_q;
    logic [FILL_W-1:0] fill_q;
    logic              full;

    dlv_frame_sync u_sync (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
        .lock_count(lock_count), .slot(slot), .locked(locked)
    );

    dlv_commutator u_comm (
        .clk(clk), .rst(rst), .feed(slot.feed), .branch(slot.branch),
        .addr(addr), .bypass(bypass)
    );

    dlv_delay_ram u_ram (
        .clk(clk), .we(slot.feed && !bypass), .addr(addr),
        .wdata(in_byte), .rdata(ram_q)
    );

    assign full = (fill_q == FILL_W'(FILL));

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q    <= '0;
            out_valid <= 1'b0;
            out_start <= 1'b0;
            sel_byp_q <= 1'b0;
            byp_q     <= '0;
        end else begin
            out_valid <= slot.feed && full;
            out_start <= slot.feed && full && slot.start;
            if (!slot.feed) begin
                if (!(in_valid == 1'b0 && locked)) fill_q <= '0;
            end else if (!full) begin
                fill_q <= fill_q + 1'b1;
            end
            if (slot.feed) begin
                sel_byp_q <= bypass;
                byp_q     <= in_byte;
            end
        end
    end

    assign out_byte = sel_byp_q ? byp_q : ram_q;

    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> locked); // R9
    AST_START_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_start |-> out_valid); // R8
    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R7
endmodule

// File: tb/tb_dlv_top.sv
module tb_dlv_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_byte = '0;
    logic       in_valid = 1'b0;
    logic [3:0] lock_count = 4'd3;
    logic [7:0] out_byte;
    logic       out_valid, out_start, locked;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string tag_lock = "R2";

    dlv_top dut (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
        .lock_count(lock_count), .out_byte(out_byte), .out_valid(out_valid),
        .out_start(out_start), .locked(locked)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // reference model state
    int m_st = 0;          // 0 search, 1 track, 2 locked
    int m_pos = 0, m_hits = 0, m_miss = 0, m_k = 0;
    logic [7:0] hist [0:16383];
    logic       e_valid, e_start;
    logic [7:0] e_byte;

    function automatic bit mk(input logic [7:0] b);
        return b == 8'h47 || b == 8'hB8;
    endfunction

    function automatic logic [7:0] payload();
        logic [7:0] b;
        do b = 8'($urandom % 256); while (mk(b));
        return b;
    endfunction

    task automatic model(input logic [7:0] b, input bit v);
        int tgt;
        tgt = (lock_count == 0) ? 1 : int'(lock_count);
        e_valid = 0; e_start = 0; e_byte = '0;
        if (!v) return;
        if (m_st == 0) begin
            if (mk(b)) begin
                m_pos = 0; m_hits = 1; m_miss = 0;
                m_st = (tgt <= 1) ? 2 : 1;
            end
        end else begin
            bit at_slot;
            at_slot = (m_pos == 203);
            m_pos = at_slot ? 0 : m_pos + 1;
            if (at_slot && m_st == 1) begin
                if (mk(b)) begin m_hits++; if (m_hits >= tgt) m_st = 2; end
                else m_st = 0;
            end else if (at_slot && m_st == 2) begin
                if (mk(b)) m_miss = 0;
                else if (m_miss == 3) begin m_miss = 0; m_st = 0; end
                else m_miss++;
            end
        end
        if (m_st == 2) begin
            hist[m_k] = b;
            if (m_k >= 2244) begin
                e_valid = 1;
                e_byte  = hist[m_k - 204 * (11 - (m_k % 12))];
                e_start = (m_k % 204) == 0;
            end
            m_k++;
        end else begin
            m_k = 0;
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic step(input logic [7:0] b, input bit v);
        model(b, v);
        in_byte = b; in_valid = v;
        @(negedge clk);
        chk(tag_lock, {7'd0, locked}, {7'd0, m_st == 2});
        chk((m_st == 2) ? "R7" : "R9", {7'd0, out_valid}, {7'd0, e_valid});
        if (e_valid) begin
            chk("R6", out_byte, e_byte);
            chk("R8", {7'd0, out_start}, {7'd0, e_start});
        end
    endtask

    task automatic send_pkt(input bit good, input bit inv);
        for (int p = 0; p < 204; p++) begin
            if ($urandom % 8 == 0) step(($urandom % 2) ? 8'h47 : 8'($urandom), 1'b0);
            if (p == 0) step(good ? (inv ? 8'hB8 : 8'h47) : 8'h00, 1'b1);
            else step(payload(), 1'b1);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", {5'd0, locked, out_valid, out_start}, 8'd0);

        // R2: marker-free noise never locks
        tag_lock = "R2";
        for (int i = 0; i < 300; i++) step(payload(), 1'b1);

        // R3: lock with count 3, then long locked run for R6/R7/R8
        tag_lock = "R3";
        lock_count = 4'd3;
        for (int n = 0; n < 20; n++) send_pkt(1'b1, n % 5 == 2);

        // R5: three misses keep lock, recovery, then four misses drop it
        tag_lock = "R5";
        for (int n = 0; n < 3; n++) send_pkt(1'b0, 1'b0);
        send_pkt(1'b1, 1'b1);
        for (int n = 0; n < 4; n++) send_pkt(1'b0, 1'b0);

        // R4: broken confirmation run with count 4
        tag_lock = "R4";
        lock_count = 4'd4;
        send_pkt(1'b1, 1'b0);
        send_pkt(1'b1, 1'b0);
        send_pkt(1'b0, 1'b0);
        send_pkt(1'b1, 1'b1);
        send_pkt(1'b1, 1'b0);
        for (int n = 0; n < 3; n++) send_pkt(1'b1, 1'b0);

        // R3: count 0 locks on first marker after a drop
        for (int n = 0; n < 4; n++) send_pkt(1'b0, 1'b0);
        tag_lock = "R3";
        lock_count = 4'd0;
        for (int i = 0; i < 50; i++) step(payload(), 1'b1);
        send_pkt(1'b1, 1'b0);
        send_pkt(1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule